// File: doc/BRIEF.md
# SPI Command Register Slave for a CAN Controller

This block is the host-facing side of a CAN controller: an SPI mode 0 slave that gives an external processor access to a 128-byte register space. Each transaction opens when chip select goes low. The first byte is a command. The bytes after it carry addresses, masks and data. The command set covers single and streaming reads and writes, a masked read-modify-write, a soft reset, and two fast paths. One fast path fills a whole transmit message buffer. The other drains a whole receive message buffer, starting from a fixed offset chosen by the command byte.

SCK, chip select and MOSI are brought into the system clock domain through synchronisers, and the bits are assembled into bytes there. A command state machine walks the byte slots of each transaction. Its states are:

- `ST_OPC`: waiting for the command byte.
- `ST_ADDR`: taking the address for read, write or modify.
- `ST_READ`: streaming reads.
- `ST_WRITE`: streaming writes.
- `ST_MASK`: taking the modify mask.
- `ST_MODIFY`: taking the modify data.
- `ST_TXLD`: loading a transmit buffer.
- `ST_RXRD`: draining a receive buffer.
- `ST_SINK`: swallowing bytes until chip select rises.

Its transitions are:

- Read, write and modify commands go from `ST_OPC` to `ST_ADDR`.
- A transmit-buffer load command goes from `ST_OPC` to `ST_TXLD`.
- A receive-buffer read command goes from `ST_OPC` to `ST_RXRD`.
- A reset command or an unknown command goes from `ST_OPC` to `ST_SINK`.
- From `ST_ADDR`, the machine goes to `ST_READ`, `ST_WRITE` or `ST_MASK`, depending on the command.
- `ST_MASK` goes to `ST_MODIFY`, and `ST_MODIFY` goes to `ST_SINK`.
- `ST_TXLD` and `ST_RXRD` go to `ST_SINK` once the buffer length is used up.
- Chip select high returns every state to `ST_OPC`.

Two test ports stand in for the CAN engine. A side write port fills receive buffer contents, and a flag-set vector raises interrupt flags. An active-low interrupt output shows whether any enabled flag is set.

Top module: `can_spi_regslave`

## Requirements
- R1: After reset, the status register (0x0E) masked with 0xEE reads 0x80 and the control register (0x0F) masked with 0x17 reads 0x07. All other registers read 0x00, `int_n` is high and `spi_miso` is low.
- R2: Command 0x03 followed by an address byte returns the byte at that address during the third byte slot. It is sent MSB first and shifted out on SCK falling edges.
- R3: Each further byte of a read returns the next address. The address wraps from 0x7F to 0x00.
- R4: Command 0x02 followed by an address byte writes the third byte to that address. Each further byte is written to the next address.
- R5: Command 0x05 with address, mask and data bytes changes only the bits set in the mask; the register becomes (old AND NOT mask) OR (data AND mask).
- R6: Command 0x40 + 2n, for n = 0, 1 or 2, writes up to 13 following bytes to consecutive addresses starting at 0x31 + 0x10·n. Bytes after the thirteenth are ignored.
- R7: Command 0x90 (n = 0) or 0x94 (n = 1) streams out 13 bytes starting at 0x61 + 0x10·n. Bytes after the thirteenth read as 0x00.
- R8: Command 0xC0 restores every register to its R1 value.
- R9: Interrupt flags are at 0x2C and enables at 0x2B. The flag bits, from bit 7 down to bit 0, are message error, wake, error, TX2, TX1, TX0, RX1, RX0. A `flag_set` bit sets the matching flag. `int_n` goes low exactly when some flag and its enable are both set, and it returns high when the flags are written to zero.
- R10: Chip select rising ends a transaction at any point. A byte of fewer than 8 bits is discarded and writes nothing.
- R11: An unknown command byte (for example 0x46 or 0x07) changes no register, and `spi_miso` stays 0 until chip select rises.
- R12: `spi_miso` is 0 during the command and address slots and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| int_n | output | 1 | Active-low interrupt |
| bk_we | input | 1 | Test-port register write strobe |
| bk_addr | input | 7 | Test-port register address |
| bk_data | input | 8 | Test-port register data |
| flag_set | input | 8 | Per-bit interrupt-flag set pulses |

## Verification
The bench uses the default parameters. These are a 7-bit address, a 13-byte message buffer, three transmit buffers and two synchroniser stages. With them, a stream started at 0x7F reaches the 0x00 wrap in two bytes, and a 14-byte fast transfer steps one byte past the buffer length on both the load and drain paths. SCK runs at 8 system clocks per half period, which stays clear of the synchroniser delay. Every MISO byte can therefore be compared in the slot where the master samples it.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;
    localparam logic [7:0] OP_WRITE     = 8'h02;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_MODIFY    = 8'h05;
    localparam logic [7:0] OP_RESET     = 8'hC0;
    localparam logic [7:0] OP_TXLD_BASE = 8'h40;
    localparam logic [7:0] OP_TXLD_MASK = 8'hF9;
    localparam logic [7:0] OP_RXRD_BASE = 8'h90;
    localparam logic [7:0] OP_RXRD_MASK = 8'hFB;

    typedef enum logic [3:0] {
        ST_OPC, ST_ADDR, ST_READ, ST_WRITE, ST_MASK,
        ST_MODIFY, ST_TXLD, ST_RXRD, ST_SINK
    } state_t;

    typedef enum logic [1:0] {KIND_READ, KIND_WRITE, KIND_MODIFY} kind_t;
endpackage

// File: rtl/can_spi_link.sv
module can_spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic [7:0] tx_byte,
    output logic       spi_miso,
    output logic [7:0] rx_byte,
    output logic       byte_valid,
    output logic       cs_idle
);
    logic [SYNC_STAGES:0]   sck_s;
    logic [SYNC_STAGES-1:0] cs_s;
    logic [SYNC_STAGES-1:0] mosi_s;
    logic [2:0]             bit_cnt;
    logic [7:0]             sh_in;
    logic [7:0]             tx_sh;
    logic                   sck_rise;
    logic                   sck_fall;
    logic                   mosi_bit;

    assign sck_rise = (sck_s[SYNC_STAGES:SYNC_STAGES-1] == 2'b01);
    assign sck_fall = (sck_s[SYNC_STAGES:SYNC_STAGES-1] == 2'b10);
    assign cs_idle  = cs_s[SYNC_STAGES-1];
    assign mosi_bit = mosi_s[SYNC_STAGES-1];
    assign spi_miso = tx_sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sck_s  <= {sck_s[SYNC_STAGES-1:0], spi_sck};
            cs_s   <= {cs_s[SYNC_STAGES-2:0], spi_cs_n};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], spi_mosi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            sh_in      <= '0;
            tx_sh      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else if (cs_idle) begin
            bit_cnt    <= '0;
            sh_in      <= '0;
            tx_sh      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (sck_rise) begin
                sh_in   <= {sh_in[6:0], mosi_bit};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_byte    <= {sh_in[6:0], mosi_bit};
                    byte_valid <= 1'b1;
                end
            end
            if (sck_fall) begin
                tx_sh <= (bit_cnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/can_spi_cmd.sv
module can_spi_cmd
    import can_spi_pkg::*;
#(
    parameter int              ADDR_W    = 7,
    parameter int              BUF_LEN   = 13,
    parameter int              TXB_COUNT = 3,
    parameter logic [ADDR_W-1:0] TXB_FIRST = 7'h31,
    parameter logic [ADDR_W-1:0] RXB_FIRST = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              soft_rst,
    output logic [7:0]        tx_byte,
    output state_t            state
);
    localparam int CNT_W = $clog2(BUF_LEN + 1);

    state_t            nxt;
    kind_t             kind;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        mask;
    logic              op_txld;
    logic              op_rxrd;
    logic [ADDR_W-1:0] txld_base;
    logic [ADDR_W-1:0] rxrd_base;

    always_comb begin
        op_txld   = ((rx_byte & OP_TXLD_MASK) == OP_TXLD_BASE) &&
                    (int'(rx_byte[2:1]) < TXB_COUNT);
        op_rxrd   = ((rx_byte & OP_RXRD_MASK) == OP_RXRD_BASE);
        txld_base = TXB_FIRST + ADDR_W'({rx_byte[2:1], 4'h0});
        rxrd_base = RXB_FIRST + ADDR_W'({rx_byte[2], 4'h0});
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPC;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_idle) begin
            nxt = ST_OPC;
        end else if (byte_valid) begin
            unique case (state)
                ST_OPC: begin
                    if (rx_byte == OP_READ || rx_byte == OP_WRITE || rx_byte == OP_MODIFY)
                        nxt = ST_ADDR;
                    else if (op_txld) nxt = ST_TXLD;
                    else if (op_rxrd) nxt = ST_RXRD;
                    else              nxt = ST_SINK;
                end
                ST_ADDR: begin
                    if (kind == KIND_READ)       nxt = ST_READ;
                    else if (kind == KIND_WRITE) nxt = ST_WRITE;
                    else                         nxt = ST_MASK;
                end
                ST_READ, ST_WRITE, ST_SINK: nxt = state;
                ST_MASK:   nxt = ST_MODIFY;
                ST_MODIFY: nxt = ST_SINK;
                ST_TXLD:   if (cnt == CNT_W'(BUF_LEN - 1)) nxt = ST_SINK;
                ST_RXRD:   if (cnt == CNT_W'(BUF_LEN))     nxt = ST_SINK;
                default:   nxt = ST_SINK;
            endcase
        end
    end

    // datapath registers stepped by received bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind    <= KIND_READ;
            ptr     <= '0;
            cnt     <= '0;
            mask    <= '0;
            tx_byte <= '0;
        end else if (cs_idle) begin
            cnt     <= '0;
            tx_byte <= '0;
        end else if (byte_valid) begin
            unique case (state)
                ST_OPC: begin
                    if (rx_byte == OP_READ)        kind <= KIND_READ;
                    else if (rx_byte == OP_WRITE)  kind <= KIND_WRITE;
                    else if (rx_byte == OP_MODIFY) kind <= KIND_MODIFY;
                    if (op_txld) begin
                        ptr <= txld_base;
                        cnt <= '0;
                    end else if (op_rxrd) begin
                        tx_byte <= rd_data;
                        ptr     <= rxrd_base + ADDR_W'(1);
                        cnt     <= CNT_W'(1);
                    end
                end
                ST_ADDR: begin
                    if (kind == KIND_READ) begin
                        tx_byte <= rd_data;
                        ptr     <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                    end else begin
                        ptr <= rx_byte[ADDR_W-1:0];
                    end
                end
                ST_READ: begin
                    tx_byte <= rd_data;
                    ptr     <= ptr + ADDR_W'(1);
                end
                ST_WRITE: ptr <= ptr + ADDR_W'(1);
                ST_MASK:  mask <= rx_byte;
                ST_TXLD: begin
                    ptr <= ptr + ADDR_W'(1);
                    cnt <= cnt + CNT_W'(1);
                end
                ST_RXRD: begin
                    if (cnt < CNT_W'(BUF_LEN)) begin
                        tx_byte <= rd_data;
                        ptr     <= ptr + ADDR_W'(1);
                        cnt     <= cnt + CNT_W'(1);
                    end else begin
                        tx_byte <= '0;
                    end
                end
                ST_MODIFY, ST_SINK: tx_byte <= '0;
                default: tx_byte <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_addr  = ptr;
        if (state == ST_ADDR)     rd_addr = rx_byte[ADDR_W-1:0];
        else if (state == ST_OPC) rd_addr = rxrd_base;
        wr_addr  = ptr;
        wr_en    = byte_valid && !cs_idle &&
                   (state == ST_WRITE || state == ST_TXLD || state == ST_MODIFY);
        wr_data  = (state == ST_MODIFY) ? ((rd_data & ~mask) | (rx_byte & mask)) : rx_byte;
        soft_rst = byte_valid && !cs_idle && (state == ST_OPC) && (rx_byte == OP_RESET);
    end
endmodule

// File: rtl/can_spi_regfile.sv
module can_spi_regfile #(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h0E,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F,
    parameter logic [ADDR_W-1:0] IE_ADDR   = 7'h2B,
    parameter logic [ADDR_W-1:0] IF_ADDR   = 7'h2C,
    parameter logic [7:0]        STAT_RST  = 8'h80,
    parameter logic [7:0]        CTRL_RST  = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              bk_we,
    input  logic [ADDR_W-1:0] bk_addr,
    input  logic [7:0]        bk_data,
    input  logic [7:0]        flag_set,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        ie_q,
    output logic [7:0]        if_q,
    output logic [7:0]        stat_q,
    output logic [7:0]        ctrl_q,
    output logic              int_n
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] if_base;

    function automatic logic [7:0] dflt(input int idx);
        if (idx == int'(STAT_ADDR)) return STAT_RST;
        if (idx == int'(CTRL_ADDR)) return CTRL_RST;
        return 8'h00;
    endfunction

    always_comb begin
        if_base = mem[IF_ADDR];
        if (bk_we && bk_addr == IF_ADDR) if_base = bk_data;
        if (wr_en && wr_addr == IF_ADDR) if_base = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= dflt(i);
            int_n <= 1'b1;
        end else if (soft_rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= dflt(i);
            int_n <= 1'b1;
        end else begin
            if (bk_we) mem[bk_addr] <= bk_data;
            if (wr_en) mem[wr_addr] <= wr_data;
            mem[IF_ADDR] <= if_base | flag_set;
            int_n        <= ~|(mem[IE_ADDR] & mem[IF_ADDR]);
        end
    end

    assign rd_data = mem[rd_addr];
    assign ie_q    = mem[IE_ADDR];
    assign if_q    = mem[IF_ADDR];
    assign stat_q  = mem[STAT_ADDR];
    assign ctrl_q  = mem[CTRL_ADDR];
endmodule

// File: rtl/can_spi_regslave.sv
module can_spi_regslave
    import can_spi_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int BUF_LEN     = 13,
    parameter int TXB_COUNT   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              int_n,
    input  logic              bk_we,
    input  logic [ADDR_W-1:0] bk_addr,
    input  logic [7:0]        bk_data,
    input  logic [7:0]        flag_set
);
    logic [7:0]        rx_byte;
    logic              byte_valid;
    logic              cs_idle;
    logic [7:0]        tx_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              soft_rst;
    state_t            state;
    logic [7:0]        ie_q;
    logic [7:0]        if_q;
    logic [7:0]        stat_q;
    logic [7:0]        ctrl_q;

    can_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .tx_byte(tx_byte), .spi_miso(spi_miso),
        .rx_byte(rx_byte), .byte_valid(byte_valid), .cs_idle(cs_idle)
    );

    can_spi_cmd #(
        .ADDR_W(ADDR_W), .BUF_LEN(BUF_LEN), .TXB_COUNT(TXB_COUNT),
        .TXB_FIRST(ADDR_W'(7'h31)), .RXB_FIRST(ADDR_W'(7'h61))
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .soft_rst(soft_rst), .tx_byte(tx_byte), .state(state)
    );

    can_spi_regfile #(
        .ADDR_W(ADDR_W),
        .STAT_ADDR(ADDR_W'(7'h0E)), .CTRL_ADDR(ADDR_W'(7'h0F)),
        .IE_ADDR(ADDR_W'(7'h2B)), .IF_ADDR(ADDR_W'(7'h2C))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bk_we(bk_we), .bk_addr(bk_addr), .bk_data(bk_data),
        .flag_set(flag_set), .rd_addr(rd_addr), .rd_data(rd_data),
        .ie_q(ie_q), .if_q(if_q), .stat_q(stat_q), .ctrl_q(ctrl_q),
        .int_n(int_n)
    );
endmodule

// File: rtl/can_spi_regslave_chk.sv
module can_spi_regslave_chk
    import can_spi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_miso,
    input logic       int_n,
    input logic [7:0] flag_set,
    input logic       soft_rst,
    input logic [7:0] ie_q,
    input logic [7:0] if_q,
    input logic [7:0] stat_q,
    input logic [7:0] ctrl_q,
    input logic       cs_idle,
    input logic       byte_valid,
    input state_t     state,
    input logic [7:0] tx_byte
);
    // R8
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (((stat_q & 8'hEE) == 8'h80) && ((ctrl_q & 8'h17) == 8'h07)));

    // R9
    flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set && !soft_rst) |=> ((if_q & $past(flag_set)) == $past(flag_set)));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == 8'h00) |=> int_n);

    // R12
    idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !spi_miso);

    // R10
    idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !byte_valid);

    // R11
    sink_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINK) |-> (tx_byte == 8'h00));
endmodule

bind can_spi_regslave can_spi_regslave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .int_n(int_n),
    .flag_set(flag_set), .soft_rst(soft_rst), .ie_q(ie_q), .if_q(if_q),
    .stat_q(stat_q), .ctrl_q(ctrl_q), .cs_idle(cs_idle),
    .byte_valid(byte_valid), .state(state), .tx_byte(tx_byte)
);

// File: tb/sim_can_spi_regslave.sv
module sim_can_spi_regslave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sck, cs_n, mosi;
    logic       miso, int_n;
    logic       bk_we;
    logic [6:0] bk_addr;
    logic [7:0] bk_data;
    logic [7:0] flag_set;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_v[$];
    logic [7:0] exp_m[$];
    string      exp_t[$];
    logic [7:0] got_v[$];

    always #4 clk = ~clk;

    can_spi_regslave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .int_n(int_n),
        .bk_we(bk_we), .bk_addr(bk_addr), .bk_data(bk_data),
        .flag_set(flag_set)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: pops the scoreboard as bytes arrive
    always @(negedge clk) begin
        while (got_v.size() > 0 && exp_v.size() > 0) begin
            logic [7:0] g, e, m;
            string t;
            g = got_v.pop_front();
            e = exp_v.pop_front();
            m = exp_m.pop_front();
            t = exp_t.pop_front();
            check(g & m, e & m, t);
        end
    end

    task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            mosi = mo[i];
            repeat (HALF) @(negedge clk);
            mi[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] mo, input bit chk, input logic [7:0] ev,
                        input logic [7:0] em, input string tag);
        logic [7:0] mi;
        if (chk) begin
            exp_v.push_back(ev);
            exp_m.push_back(em);
            exp_t.push_back(tag);
        end
        spi_byte(mo, mi);
        if (chk) got_v.push_back(mi);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        cs_lo();
        xfer(8'h02, 1'b0, 8'h00, 8'h00, "");
        xfer(a, 1'b0, 8'h00, 8'h00, "");
        xfer(d, 1'b0, 8'h00, 8'h00, "");
        cs_hi();
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] e,
                          input logic [7:0] m, input string tag);
        cs_lo();
        xfer(8'h03, 1'b1, 8'h00, 8'hFF, "R12 opcode slot");
        xfer(a, 1'b1, 8'h00, 8'hFF, "R12 address slot");
        xfer(8'h00, 1'b1, e, m, tag);
        cs_hi();
    endtask

    task automatic bk_wr(input logic [6:0] a, input logic [7:0] d);
        bk_addr = a;
        bk_data = d;
        bk_we   = 1'b1;
        @(negedge clk);
        bk_we   = 1'b0;
    endtask

    task automatic pulse_flags(input logic [7:0] f);
        flag_set = f;
        @(negedge clk);
        flag_set = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        bk_we = 1'b0; bk_addr = '0; bk_data = '0; flag_set = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check({7'd0, int_n}, 8'h01, "R1 int_n after reset");
        check({7'd0, miso}, 8'h00, "R1 miso after reset");
        rd_reg(8'h0E, 8'h80, 8'hEE, "R1 status default");
        rd_reg(8'h0F, 8'h07, 8'h17, "R1 control default");
        rd_reg(8'h20, 8'h00, 8'hFF, "R1 plain register default");

        // R4 streaming write, R2/R3 streaming read
        cs_lo();
        xfer(8'h02, 1'b0, 0, 0, "");
        xfer(8'h20, 1'b0, 0, 0, "");
        xfer(8'hA5, 1'b0, 0, 0, "");
        xfer(8'h3C, 1'b0, 0, 0, "");
        cs_hi();
        cs_lo();
        xfer(8'h03, 1'b1, 8'h00, 8'hFF, "R12 opcode slot");
        xfer(8'h20, 1'b1, 8'h00, 8'hFF, "R12 address slot");
        xfer(8'h00, 1'b1, 8'hA5, 8'hFF, "R2 R4 read first byte");
        xfer(8'h00, 1'b1, 8'h3C, 8'hFF, "R3 R4 read next address");
        cs_hi();

        // R3 wrap from 0x7F to 0x00
        cs_lo();
        xfer(8'h02, 1'b0, 0, 0, "");
        xfer(8'h7F, 1'b0, 0, 0, "");
        xfer(8'h11, 1'b0, 0, 0, "");
        xfer(8'h22, 1'b0, 0, 0, "");
        cs_hi();
        cs_lo();
        xfer(8'h03, 1'b0, 0, 0, "");
        xfer(8'h7F, 1'b0, 0, 0, "");
        xfer(8'h00, 1'b1, 8'h11, 8'hFF, "R3 read at 0x7F");
        xfer(8'h00, 1'b1, 8'h22, 8'hFF, "R3 read wraps to 0x00");
        cs_hi();

        // R5 bit modify: (A5 & F0) | (50 & 0F) = A0
        cs_lo();
        xfer(8'h05, 1'b0, 0, 0, "");
        xfer(8'h20, 1'b0, 0, 0, "");
        xfer(8'h0F, 1'b0, 0, 0, "");
        xfer(8'h50, 1'b0, 0, 0, "");
        cs_hi();
        rd_reg(8'h20, 8'hA0, 8'hFF, "R5 masked update");

        // R6 transmit buffer 1 load of 14 bytes
        wr_reg(8'h4E, 8'h77);
        cs_lo();
        xfer(8'h42, 1'b0, 0, 0, "");
        for (int i = 0; i < 14; i++) xfer(8'h10 + 8'(i), 1'b0, 0, 0, "");
        cs_hi();
        cs_lo();
        xfer(8'h03, 1'b0, 0, 0, "");
        xfer(8'h41, 1'b0, 0, 0, "");
        for (int i = 0; i < 13; i++) xfer(8'h00, 1'b1, 8'h10 + 8'(i), 8'hFF, "R6 tx buffer 1 byte");
        xfer(8'h00, 1'b1, 8'h77, 8'hFF, "R6 byte past buffer ignored");
        cs_hi();
        cs_lo();
        xfer(8'h40, 1'b0, 0, 0, "");
        xfer(8'h5C, 1'b0, 0, 0, "");
        cs_hi();
        rd_reg(8'h31, 8'h5C, 8'hFF, "R6 tx buffer 0 first byte");

        // R7 receive buffer drains
        for (int i = 0; i < 13; i++) bk_wr(7'h71 + 7'(i), 8'hC0 + 8'(i));
        bk_wr(7'h7E, 8'h99);
        cs_lo();
        xfer(8'h94, 1'b1, 8'h00, 8'hFF, "R12 rx read opcode slot");
        for (int i = 0; i < 13; i++) xfer(8'h00, 1'b1, 8'hC0 + 8'(i), 8'hFF, "R7 rx buffer 1 byte");
        xfer(8'h00, 1'b1, 8'h00, 8'hFF, "R7 past buffer reads zero");
        cs_hi();
        bk_wr(7'h61, 8'h5A);
        cs_lo();
        xfer(8'h90, 1'b0, 0, 0, "");
        xfer(8'h00, 1'b1, 8'h5A, 8'hFF, "R7 rx buffer 0 first byte");
        cs_hi();

        // R11 unknown commands
        cs_lo();
        xfer(8'h46, 1'b0, 0, 0, "");
        xfer(8'hAA, 1'b1, 8'h00, 8'hFF, "R11 miso zero after unknown");
        xfer(8'hFF, 1'b1, 8'h00, 8'hFF, "R11 miso zero after unknown");
        cs_hi();
        cs_lo();
        xfer(8'h07, 1'b0, 0, 0, "");
        xfer(8'h31, 1'b1, 8'h00, 8'hFF, "R11 miso zero after unknown");
        xfer(8'hEE, 1'b1, 8'h00, 8'hFF, "R11 miso zero after unknown");
        cs_hi();
        rd_reg(8'h31, 8'h5C, 8'hFF, "R11 register unchanged");

        // R10 partial byte discarded
        cs_lo();
        xfer(8'h02, 1'b0, 0, 0, "");
        xfer(8'h22, 1'b0, 0, 0, "");
        for (int i = 7; i >= 3; i--) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_hi();
        rd_reg(8'h22, 8'h00, 8'hFF, "R10 partial byte not written");

        // R9 interrupts: enable TX0 (bit2)
        wr_reg(8'h2B, 8'h04);
        pulse_flags(8'h02);
        check({7'd0, int_n}, 8'h01, "R9 disabled flag keeps int_n high");
        rd_reg(8'h2C, 8'h02, 8'hFF, "R9 RX1 flag at bit1");
        pulse_flags(8'h04);
        check({7'd0, int_n}, 8'h00, "R9 enabled TX0 flag drives int_n low");
        wr_reg(8'h2C, 8'h00);
        repeat (3) @(negedge clk);
        check({7'd0, int_n}, 8'h01, "R9 clearing flags releases int_n");

        // R8 reset command
        cs_lo();
        xfer(8'hC0, 1'b0, 0, 0, "");
        cs_hi();
        rd_reg(8'h20, 8'h00, 8'hFF, "R8 register cleared by reset command");
        rd_reg(8'h0E, 8'h80, 8'hEE, "R8 status default");
        rd_reg(8'h0F, 8'h07, 8'h17, "R8 control default");

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule